// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog

This block is an independent watchdog. Its countdown logic runs on a separate slow clock, and a small write port on the system clock drives it. The counter is loaded with all ones, counts down through a power-of-two prescaler, and emits a one-cycle reset pulse on the slow clock when the count runs out. The count then starts again from the reload value. Software prevents the pulse by writing a refresh key before the count expires.

The three configuration registers are the prescaler, the reload value and the window. A write to any of them takes effect only after an unlock key. Each accepted write is carried into the slow clock domain by a toggle handshake. A per-register busy flag stays set until the slow domain has applied the new value. The watchdog can be started by a start key or by a strap sampled during reset. Once started, it cannot be stopped.

The window adds a second check: a refresh that arrives while the count is still above the window value causes a reset pulse instead of a reload. Writing the window register also reloads the counter. A debug freeze input can hold the counter while the core is halted.

Top module: `keyed_window_watchdog`

## Requirements
- R1: With `hw_start` low during reset, no reset pulse is produced until key 0xCCCC is written at address 0. After that key, pulses appear.
- R2: With `hw_start` high during reset, the watchdog runs without any key. It counts from all ones and gives its first pulse (2^CNT_W-1)*div slow cycles after reset release.
- R3: While running and not refreshed, the pulse repeats exactly every reload*div slow cycles.
- R4: Prescaler code c (address 1, bits [PRE_W-1:0]) divides by 2^(c+PRE_MIN_LOG2). The division is capped at 2^PRE_MAX_LOG2, so by default codes 6 and 7 both give 256.
- R5: Key 0xAAAA at address 0 reloads the counter from the reload register (address 2, bits [CNT_W-1:0]) and restarts the prescaler.
- R6: Writes at addresses 1, 2 and 3 are accepted only while unlocked. Key 0x5555 unlocks. Any other key value locks again. A locked write changes nothing and raises no busy flag.
- R7: `cfg_busy` bit 0 belongs to the prescaler, bit 1 to the reload value and bit 2 to the window. A bit is 0 after reset. It is set on the cycle after an accepted write and clears only after the slow domain has applied the value. A write to a register whose bit is set is ignored.
- R8: Writing the window register (address 3) reloads the counter, even when the value written is all ones.
- R9: A refresh key that arrives while the count is above the window value gives a reset pulse instead of a plain reload. The window resets to all ones, which disables this check.
- R10: While `dbg_halt` and `dbg_freeze_en` are both high, the counter and prescaler hold. Either signal alone has no effect.
- R11: Once the watchdog is running, no key value stops it.
- R12: The reset pulse is exactly one slow clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the write port |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | 0 key, 1 prescaler, 2 reload, 3 window |
| reg_wdata | input | 16 | Write data |
| cfg_busy | output | 3 | Per-register update-in-flight flags |
| wd_clk | input | 1 | Slow watchdog clock |
| wd_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| hw_start | input | 1 | Start strap, sampled while in reset |
| dbg_halt | input | 1 | Core halted by the debugger |
| dbg_freeze_en | input | 1 | Allow the counter to freeze while halted |
| wd_reset_pulse | output | 1 | Watchdog reset request, slow domain |

## Verification
The bench builds the block with CNT_W=6, PRE_MIN_LOG2=2 and PRE_MAX_LOG2=5. The longest timeout is then 63*32 slow cycles, so many exact pulse-to-pulse intervals fit in a short run. This setting also reaches the prescaler cap at code 3, which lets codes 3, 5 and 7 show the clamping behaviour. A small counter also means a window of 5 sits well inside the reload range. Early and in-window refreshes can therefore both be tried within a few tens of slow cycles.

// File: rtl/wdg_pkg.sv
// Shared constants for the keyed watchdog: key values, address map, channels.
package wdg_pkg;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;
    localparam int N_CFG  = 3;

    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [ADDR_W-1:0] {
        ADR_KEY    = 2'd0,
        ADR_PRESC  = 2'd1,
        ADR_RELOAD = 2'd2,
        ADR_WINDOW = 2'd3
    } wdg_addr_e;

    // busy bit / handshake channel index per configuration register
    localparam int CH_PRESC  = 0;
    localparam int CH_RELOAD = 1;
    localparam int CH_WINDOW = 2;
endpackage

// File: rtl/wdg_sync_bit.sv
// Multi-flop level synchronizer.
// Assumes: the input is a level or a toggle that holds for several destination cycles.
module wdg_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_bus_regs.sv
// System-domain write port: key decoding, unlock state, configuration shadows,
// and a request toggle per channel.
// Assumes: ack_lvl is the slow domain's applied-level, already synchronized back.
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [KEY_W-1:0]     wr_data,
    input  logic [N_CFG-1:0]     ack_lvl,
    output logic                 refresh_tgl,
    output logic                 start_tgl,
    output logic [N_CFG-1:0]     cfg_req,
    output logic [PRE_W-1:0]     presc_sh,
    output logic [CNT_W-1:0]     reload_sh,
    output logic [CNT_W-1:0]     window_sh,
    output logic [N_CFG-1:0]     busy
);
    wdg_addr_e        addr;
    logic             unlocked;
    logic [N_CFG-1:0] cfg_hit;

    assign addr = wdg_addr_e'(wr_addr);
    assign busy = cfg_req ^ ack_lvl;

    // accepted config writes: unlocked, right address, channel idle
    always_comb begin
        cfg_hit = '0;
        if (wr_en && unlocked) begin
            case (addr)
                ADR_PRESC:  cfg_hit[CH_PRESC]  = 1'b1;
                ADR_RELOAD: cfg_hit[CH_RELOAD] = 1'b1;
                ADR_WINDOW: cfg_hit[CH_WINDOW] = 1'b1;
                default:    cfg_hit = '0;
            endcase
        end
        cfg_hit = cfg_hit & ~busy;
    end

    // key register: unlock state and command toggles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked    <= 1'b0;
            refresh_tgl <= 1'b0;
            start_tgl   <= 1'b0;
        end else if (wr_en && addr == ADR_KEY) begin
            unlocked <= (wr_data == KEY_UNLOCK);
            if (wr_data == KEY_REFRESH) refresh_tgl <= ~refresh_tgl;
            if (wr_data == KEY_START)   start_tgl   <= ~start_tgl;
        end
    end

    // configuration shadows and per-channel request toggles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_sh  <= '0;
            reload_sh <= '1;
            window_sh <= '1;
            cfg_req   <= '0;
        end else begin
            if (cfg_hit[CH_PRESC])  presc_sh  <= wr_data[PRE_W-1:0];
            if (cfg_hit[CH_RELOAD]) reload_sh <= wr_data[CNT_W-1:0];
            if (cfg_hit[CH_WINDOW]) window_sh <= wr_data[CNT_W-1:0];
            cfg_req <= cfg_req ^ cfg_hit;
        end
    end
endmodule

// File: rtl/wdg_count_core.sv
// Slow-domain watchdog core: applies configuration, runs prescaler and down-counter,
// checks the refresh window and issues the reset pulse.
// Assumes: all *_lvl inputs are synchronized. Shadows hold steady while their request is pending.
module wdg_count_core
    import wdg_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int PRE_MIN_LOG2 = 2,
    parameter int PRE_MAX_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic             halt,
    input  logic             freeze_en,
    input  logic             refresh_lvl,
    input  logic             start_lvl,
    input  logic [N_CFG-1:0] cfg_lvl,
    input  logic [PRE_W-1:0] presc_sh,
    input  logic [CNT_W-1:0] reload_sh,
    input  logic [CNT_W-1:0] window_sh,
    output logic [N_CFG-1:0] cfg_ack,
    output logic             wd_reset
);
    localparam int PC_W = PRE_MAX_LOG2;

    logic             refresh_prev, start_prev, running, frozen;
    logic [N_CFG-1:0] cfg_prev, cfg_ev;
    logic             refresh_ev, start_ev;
    logic [PRE_W-1:0] presc_act;
    logic [CNT_W-1:0] reload_act, window_act, count;
    logic [PC_W-1:0]  pre_cnt, pre_term;

    assign refresh_ev = refresh_lvl ^ refresh_prev;
    assign start_ev   = start_lvl ^ start_prev;
    assign cfg_ev     = cfg_lvl ^ cfg_prev;
    assign cfg_ack    = cfg_prev;
    assign frozen     = halt & freeze_en;

    // prescaler terminal count from the code, clamped at the largest division
    always_comb begin
        int lg;
        lg = int'(presc_act) + PRE_MIN_LOG2;
        if (lg > PRE_MAX_LOG2) lg = PRE_MAX_LOG2;
        pre_term = PC_W'((1 << lg) - 1);
    end

    // edge trackers for toggles; the config tracker doubles as acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_prev <= 1'b0;
            start_prev   <= 1'b0;
            cfg_prev     <= '0;
        end else begin
            refresh_prev <= refresh_lvl;
            start_prev   <= start_lvl;
            cfg_prev     <= cfg_lvl;
        end
    end

    // active configuration, captured from the stable shadows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_act  <= '0;
            reload_act <= '1;
            window_act <= '1;
        end else begin
            if (cfg_ev[CH_PRESC])  presc_act  <= presc_sh;
            if (cfg_ev[CH_RELOAD]) reload_act <= reload_sh;
            if (cfg_ev[CH_WINDOW]) window_act <= window_sh;
        end
    end

    // run state: strap at reset, start key later, never cleared
    always_ff @(posedge clk) begin
        if (!rst_n)        running <= strap;
        else if (start_ev) running <= 1'b1;
    end

    // countdown, refresh and window check, reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '1;
            pre_cnt  <= '0;
            wd_reset <= 1'b0;
        end else begin
            wd_reset <= 1'b0;
            if (!running) begin
                pre_cnt <= '0;
            end else if (refresh_ev && count > window_act) begin
                wd_reset <= 1'b1;
                count    <= reload_act;
                pre_cnt  <= '0;
            end else if (refresh_ev || cfg_ev[CH_WINDOW]) begin
                count   <= reload_act;
                pre_cnt <= '0;
            end else if (!frozen) begin
                if (pre_cnt >= pre_term) begin
                    pre_cnt <= '0;
                    if (count <= CNT_W'(1)) begin
                        wd_reset <= 1'b1;
                        count    <= reload_act;
                    end else begin
                        count <= count - CNT_W'(1);
                    end
                end else begin
                    pre_cnt <= pre_cnt + PC_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/keyed_window_watchdog.sv
// Top of the keyed windowed watchdog: system-domain write port, synchronizers both ways,
// slow-domain counting core.
// Assumes: sys_clk and wd_clk are unrelated. Both resets are applied together at power-up.
module keyed_window_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int PRE_MIN_LOG2 = 2,
    parameter int PRE_MAX_LOG2 = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                sys_clk,
    input  logic                sys_rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [KEY_W-1:0]    reg_wdata,
    output logic [N_CFG-1:0]    cfg_busy,
    input  logic                wd_clk,
    input  logic                wd_rst_n,
    input  logic                hw_start,
    input  logic                dbg_halt,
    input  logic                dbg_freeze_en,
    output logic                wd_reset_pulse
);
    logic             refresh_tgl, start_tgl, refresh_lvl, start_lvl;
    logic             halt_wd, frz_en_wd;
    logic [N_CFG-1:0] cfg_req, cfg_lvl, cfg_ack_wd, cfg_ack_sys;
    logic [PRE_W-1:0] presc_sh;
    logic [CNT_W-1:0] reload_sh, window_sh;

    wdg_bus_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(sys_clk), .rst_n(sys_rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .ack_lvl(cfg_ack_sys),
        .refresh_tgl(refresh_tgl), .start_tgl(start_tgl), .cfg_req(cfg_req),
        .presc_sh(presc_sh), .reload_sh(reload_sh), .window_sh(window_sh),
        .busy(cfg_busy)
    );

    wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_refresh (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(refresh_tgl), .q(refresh_lvl));
    wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_start (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(start_tgl), .q(start_lvl));
    wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_halt (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(dbg_halt), .q(halt_wd));
    wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_frz (
        .clk(wd_clk), .rst_n(wd_rst_n), .d(dbg_freeze_en), .q(frz_en_wd));

    for (genvar i = 0; i < N_CFG; i++) begin : g_chan
        wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_req (
            .clk(wd_clk), .rst_n(wd_rst_n), .d(cfg_req[i]), .q(cfg_lvl[i]));
        wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_ack (
            .clk(sys_clk), .rst_n(sys_rst_n), .d(cfg_ack_wd[i]), .q(cfg_ack_sys[i]));
    end

    wdg_count_core #(
        .CNT_W(CNT_W), .PRE_W(PRE_W),
        .PRE_MIN_LOG2(PRE_MIN_LOG2), .PRE_MAX_LOG2(PRE_MAX_LOG2)
    ) u_core (
        .clk(wd_clk), .rst_n(wd_rst_n), .strap(hw_start),
        .halt(halt_wd), .freeze_en(frz_en_wd),
        .refresh_lvl(refresh_lvl), .start_lvl(start_lvl), .cfg_lvl(cfg_lvl),
        .presc_sh(presc_sh), .reload_sh(reload_sh), .window_sh(window_sh),
        .cfg_ack(cfg_ack_wd), .wd_reset(wd_reset_pulse)
    );
endmodule

// File: rtl/wdg_checker.sv
// Protocol checks on the system-domain side of the watchdog, bound to the top.
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PRE_W = 3
) (
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [KEY_W-1:0]  reg_wdata,
    input logic [N_CFG-1:0]  cfg_busy,
    input logic              refresh_tgl,
    input logic              start_tgl,
    input logic [PRE_W-1:0]  presc_sh,
    input logic [CNT_W-1:0]  reload_sh,
    input logic [CNT_W-1:0]  window_sh
);
    // R7: a busy flag rises only after a write to its own register
    assert_busy_presc_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(cfg_busy[CH_PRESC]) |-> $past(reg_wr && reg_addr == ADR_PRESC));
    assert_busy_reload_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(cfg_busy[CH_RELOAD]) |-> $past(reg_wr && reg_addr == ADR_RELOAD));
    assert_busy_window_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(cfg_busy[CH_WINDOW]) |-> $past(reg_wr && reg_addr == ADR_WINDOW));

    // R7: a value in flight is never overwritten
    assert_presc_held_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $past(cfg_busy[CH_PRESC]) |-> $stable(presc_sh));
    assert_reload_held_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $past(cfg_busy[CH_RELOAD]) |-> $stable(reload_sh));
    assert_window_held_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $past(cfg_busy[CH_WINDOW]) |-> $stable(window_sh));

    // R6: a non-unlock key followed by a reload write leaves the reload channel idle
    assert_relock_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (reg_wr && reg_addr == ADR_RELOAD &&
         $past(reg_wr && reg_addr == ADR_KEY && reg_wdata != KEY_UNLOCK))
        |=> !$rose(cfg_busy[CH_RELOAD]));

    // R5: the refresh command only moves on a refresh key
    assert_refresh_key_R5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !$stable(refresh_tgl) |-> $past(reg_wr && reg_addr == ADR_KEY && reg_wdata == KEY_REFRESH));

    // R1: the start command only moves on a start key
    assert_start_key_R1: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !$stable(start_tgl) |-> $past(reg_wr && reg_addr == ADR_KEY && reg_wdata == KEY_START));
endmodule

bind keyed_window_watchdog wdg_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_busy(cfg_busy), .refresh_tgl(refresh_tgl),
    .start_tgl(start_tgl), .presc_sh(presc_sh), .reload_sh(reload_sh),
    .window_sh(window_sh)
);

// File: tb/keyed_window_watchdog_bench.sv
module keyed_window_watchdog_bench;
    localparam int CNT_W = 6;
    localparam int PRE_W = 3;

    logic       sys_clk = 1'b0, wd_clk = 1'b0;
    logic       sys_rst_n = 1'b0, wd_rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0] cfg_busy;
    logic       hw_start = 1'b0, dbg_halt = 1'b0, dbg_freeze_en = 1'b0;
    logic       wd_reset_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    keyed_window_watchdog #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MIN_LOG2(2), .PRE_MAX_LOG2(5), .SYNC_STAGES(2)
    ) u_keyed_window_watchdog (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_busy(cfg_busy), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .hw_start(hw_start), .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en),
        .wd_reset_pulse(wd_reset_pulse)
    );

    always #2 sys_clk = ~sys_clk;
    initial begin
        #1;
        forever #8 wd_clk = ~wd_clk;
    end

    typedef struct packed {
        logic [2:0] code;
        logic [5:0] reload;
        int         interval;
    } vec_t;

    // prescaler code, reload, expected pulse interval in slow cycles
    localparam vec_t TBL [7] = '{
        '{3'd0, 6'd63, 252},
        '{3'd1, 6'd10, 80},
        '{3'd2, 6'd5,  80},
        '{3'd3, 6'd3,  96},
        '{3'd5, 6'd2,  64},
        '{3'd7, 6'd1,  32},
        '{3'd0, 6'd10, 40}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge sys_clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge sys_clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (cfg_busy != 0 && cyc < 200) begin
            @(posedge sys_clk); #1;
            cyc++;
        end
    endtask

    task automatic wait_wd(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge wd_clk); #1;
        end
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge wd_clk); #1;
            if (wd_reset_pulse) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic do_reset(input logic strap);
        hw_start = strap;
        sys_rst_n = 1'b0; wd_rst_n = 1'b0;
        wait_wd(5);
        sys_rst_n = 1'b1; wd_rst_n = 1'b1;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #760000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int n, c;
        do_reset(1'b0);
        check(cfg_busy == 0, "R7 busy clear after reset", cfg_busy, 0);
        check(wd_reset_pulse == 0, "R1 no pulse after reset", wd_reset_pulse, 0);

        // R1: idle until the start key
        wait_pulse(400, n);
        check(n < 0, "R1 no pulse before start", n, -1);
        wr(2'd0, 16'hCCCC);
        wait_pulse(300, n);
        check(n > 0, "R1 pulse after start key", n, 255);
        wait_pulse(300, n);
        check(n == 252, "R3 default interval", n, 252);
        wait_wd(1);
        check(wd_reset_pulse == 0, "R12 pulse one cycle wide", wd_reset_pulse, 0);

        // R3 R4: table of prescaler and reload settings
        for (int i = 0; i < 7; i++) begin
            wr(2'd0, 16'h5555);
            wr(2'd1, {13'd0, TBL[i].code});
            check(cfg_busy[0] == 1'b1, "R7 prescaler busy after write", cfg_busy[0], 1);
            wr(2'd2, {10'd0, TBL[i].reload});
            wait_idle(c);
            wait_pulse(5000, n);
            wait_pulse(5000, n);
            check(n == TBL[i].interval, "R4 R3 interval for code/reload", n, TBL[i].interval);
        end

        // R5: refresh restarts the count
        wait_pulse(100, n);
        wait_wd(20);
        wr(2'd0, 16'hAAAA);
        wait_pulse(100, n);
        check(n >= 41 && n <= 46, "R5 refresh delays the pulse", n, 43);

        // R6: relock by other key values, locked writes ignored
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd50);
        check(cfg_busy == 0, "R6 locked write raises no busy", cfg_busy, 0);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd50);
        check(cfg_busy == 0, "R6 relocked write raises no busy", cfg_busy, 0);
        wait_pulse(100, n);
        wait_pulse(100, n);
        check(n == 40, "R6 reload unchanged while locked", n, 40);

        // R7: second write during busy is dropped, busy clears after handshake
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd20);
        wr(2'd2, 16'd30);
        wait_idle(c);
        check(c >= 4 && c <= 40, "R7 busy duration", c, 14);
        wait_pulse(300, n);
        wait_pulse(300, n);
        check(n == 80, "R7 write during busy ignored", n, 80);
        wr(2'd2, 16'd10);
        wait_idle(c);
        wait_pulse(300, n);

        // R8: window write reloads, even at all ones
        wait_pulse(100, n);
        wait_wd(20);
        wr(2'd3, 16'd63);
        wait_pulse(100, n);
        check(n >= 41 && n <= 46, "R8 window write reloads", n, 43);

        // R9: early refresh gives a pulse, in-window refresh reloads
        wr(2'd3, 16'd5);
        wait_idle(c);
        wait_pulse(100, n);
        wr(2'd0, 16'hAAAA);
        wait_pulse(10, n);
        check(n > 0 && n <= 6, "R9 early refresh causes pulse", n, 3);
        wait_pulse(100, n);
        wait_wd(32);
        wr(2'd0, 16'hAAAA);
        wait_pulse(100, n);
        check(n >= 41 && n <= 46, "R9 in-window refresh reloads", n, 43);
        wr(2'd0, 16'h5555);
        wr(2'd3, 16'd63);
        wait_idle(c);

        // R10: freeze holds the count; halt alone does not
        wait_pulse(100, n);
        wait_wd(10);
        dbg_halt = 1'b1; dbg_freeze_en = 1'b1;
        wait_pulse(100, n);
        check(n < 0, "R10 frozen counter gives no pulse", n, -1);
        dbg_halt = 1'b0; dbg_freeze_en = 1'b0;
        wait_pulse(100, n);
        check(n >= 26 && n <= 36, "R10 count resumes after freeze", n, 30);
        wait_wd(10);
        dbg_halt = 1'b1;
        wait_pulse(60, n);
        check(n > 0, "R10 halt without freeze enable keeps counting", n, 30);
        dbg_halt = 1'b0;

        // R11: no key stops a running watchdog
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hFFFF);
        wait_pulse(100, n);
        check(n > 0, "R11 still running after keys", n, 40);

        // R2: hardware start strap
        do_reset(1'b1);
        wait_pulse(400, n);
        check(n >= 250 && n <= 254, "R2 strap start first pulse", n, 252);

        summary();
        $finish;
    end
endmodule